// File: doc/BRIEF.md
# Flash Self-Programming Sequencer

This block is the control and status register that a CPU core uses to run programming operations on its own flash. Software writes one command bit together with the operation-enable bit. That arms a short window. A store-program strobe from the core inside the window then starts the command. If no strobe arrives, the command lapses. The possible commands are page erase, page write, page-buffer word load, lock-bit write, and re-enabling reads of the read-while-write region. Erase and write are passed to an external flash controller, and the block waits for that controller to report done.

The block records when the read-while-write region is busy and so blocked for reads. It tracks whether the page buffer is part-way through being filled. It holds the lock bits and returns lock or fuse bits for a load-program strobe that comes soon after a lock command is armed. It raises a ready interrupt whenever no operation is pending.

A three-state machine does the sequencing:
- **IDLE**: no operation is pending.
- **ARMED**: a command is waiting for its strobe, and a cycle counter runs.
- **PROG**: an erase or write is running in the flash controller.

The transitions are:
- **arm** (IDLE→ARMED): a valid command write.
- **fire** (ARMED→IDLE): a strobe for a load, lock or re-enable command.
- **launch** (ARMED→PROG): a strobe for an erase or write command.
- **lapse** (ARMED→IDLE): the window ends with no strobe.
- **finish** (PROG→IDLE): the controller reports done.

Top module: `selfprog_ctl`

## Requirements
- R1: After reset, the register reads 0x00, the interrupt is low, the region is not busy, the buffer is not loading, and the lock bits are 0x00.
- R2: The register layout is interrupt enable at bit 7, region busy at bit 6, erase at bit 1, write at bit 2, lock set at bit 3, re-enable at bit 4 and operation enable at bit 0. Bit 5 always reads 0. Bit 6 cannot be written. The interrupt enable bit is written by every register write.
- R3: The interrupt output equals interrupt enable AND the global interrupt input AND NOT operation enable.
- R4: An erase (bit 1) or write (bit 2) command followed by a strobe pulses `fc_erase_go` or `fc_write_go` for one cycle, on the cycle after the strobe edge. The same command sets the busy bit. Operation enable then stays at 1 until `fc_done`, and the interrupt rises on the cycle after `fc_done`.
- R5: A strobe is accepted on the 1st to 4th clock edge after the arming write. With no strobe, operation enable and the command bits read 0 after the 4th edge, and no operation starts.
- R6: A re-enable command (bit 4) followed by a strobe clears the busy bit and pulses `pbuf_clr` for one cycle.
- R7: During PROG, register writes change only the interrupt enable bit. A re-enable written in PROG is dropped, and the busy bit stays set.
- R8: Arming a re-enable command while the page buffer is loading clears `pbuf_loading` at once.
- R9: A write of operation enable alone, followed by a strobe, pulses `pgload_go`, clears the busy bit and sets `pbuf_loading`.
- R10: A lock command (bit 3) followed by a strobe copies `r0_data` into `lock_bits` and returns the register to IDLE.
- R11: A load strobe on the 1st to 3rd edge after arming a lock command pulses `rd_valid`. It returns `lock_bits` when `z0` is 0 and `fuse_bits` when `z0` is 1. A load strobe on the 4th edge returns nothing.
- R12: A write that sets operation enable with more than one command bit is ignored apart from interrupt enable, so no window opens.
- R13: Command bits written without operation enable are not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt flag from the core |
| store_stb | input | 1 | Store-program strobe |
| load_stb | input | 1 | Load-program strobe |
| z0 | input | 1 | Address bit 0; selects lock (0) or fuse (1) readback |
| r0_data | input | 8 | Data byte used for lock-bit writes |
| fuse_bits | input | 8 | Current fuse bits |
| fc_done | input | 1 | Flash controller finished erase or write |
| fc_erase_go | output | 1 | Start page erase pulse |
| fc_write_go | output | 1 | Start page write pulse |
| pgload_go | output | 1 | Load one word into the page buffer |
| pbuf_clr | output | 1 | Clear the page buffer |
| rww_busy | output | 1 | Read-while-write region blocked |
| pbuf_loading | output | 1 | Page buffer partly filled |
| lock_bits | output | 8 | Stored lock bits |
| rd_valid | output | 1 | Lock/fuse readback valid |
| rd_data | output | 8 | Lock/fuse readback value |
| irq | output | 1 | Ready interrupt |

## Verification
The register path is driven by a vector table. The table pairs writes that leave operation enable at 0 with both global-flag values. This separates the interrupt rule from command retention, and it shows which bits cannot be written. The command path is then tried with a strobe on the first edge and on the last allowed edge, with no strobe at all, and with a strobe one edge late. These runs separate acceptance from lapse. Re-enabling the region is tried in three situations: during programming, after programming, and over a half-loaded buffer. Lock readback is probed on its last valid edge and one edge past it, with both address-bit values.

// File: rtl/selfprog_pkg.sv
`timescale 1ns/1ps
package selfprog_pkg;
    // Register bit positions (software-visible layout)
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_ERASE = 1;
    localparam int unsigned B_WRITE = 2;
    localparam int unsigned B_LOCK  = 3;
    localparam int unsigned B_REEN  = 4;
    localparam int unsigned B_RSVD  = 5;
    localparam int unsigned B_BUSY  = 6;
    localparam int unsigned B_IE    = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PROG  = 2'd2
    } sp_state_e;

    typedef enum logic [2:0] {
        CMD_LOAD  = 3'd0,
        CMD_ERASE = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_LOCK  = 3'd3,
        CMD_REEN  = 3'd4
    } sp_cmd_e;
endpackage

// File: rtl/sp_cmd_decode.sv
`timescale 1ns/1ps
// Classifies a register write: is it a valid arming write, and which command.
module sp_cmd_decode
    import selfprog_pkg::*;
(
    input  logic [7:0] wdata,
    output logic       arm,
    output sp_cmd_e    cmd
);
    logic [3:0] cmd_bits;

    always_comb begin
        cmd_bits = {wdata[B_REEN], wdata[B_LOCK], wdata[B_WRITE], wdata[B_ERASE]};
        // at most one command bit may accompany the enable
        arm      = wdata[B_EN] && ((cmd_bits & (cmd_bits - 4'd1)) == 4'd0);
        if (cmd_bits[0])      cmd = CMD_ERASE;
        else if (cmd_bits[1]) cmd = CMD_WRITE;
        else if (cmd_bits[2]) cmd = CMD_LOCK;
        else if (cmd_bits[3]) cmd = CMD_REEN;
        else                  cmd = CMD_LOAD;
    end
endmodule

// File: rtl/sp_window.sv
`timescale 1ns/1ps
// Counts edges spent in the armed state; flags the last strobe edge and the
// shorter readback window.
module sp_window #(
    parameter int unsigned WIN    = 4,
    parameter int unsigned RD_WIN = 3,
    localparam int unsigned CW    = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          expire,
    output logic          rd_open
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    always_comb begin
        expire  = run && (cnt == CW'(WIN - 1));
        rd_open = run && (cnt < CW'(RD_WIN));
    end
endmodule

// File: rtl/sp_region.sv
`timescale 1ns/1ps
// Tracks the read-while-write busy flag and the partly-filled page buffer.
module sp_region (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_go,
    input  logic load_go,
    input  logic reen_go,
    input  logic reen_arm,
    output logic busy,
    output logic loading
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 busy <= 1'b0;
        else if (prog_go)           busy <= 1'b1;
        else if (load_go || reen_go) busy <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    loading <= 1'b0;
        else if (load_go)                              loading <= 1'b1;
        else if (reen_arm || reen_go || prog_go)       loading <= 1'b0;
    end
endmodule

// File: rtl/selfprog_ctl.sv
`timescale 1ns/1ps
module selfprog_ctl
    import selfprog_pkg::*;
#(
    parameter int unsigned WIN    = 4,
    parameter int unsigned RD_WIN = 3,
    parameter int unsigned DW     = 8,
    localparam int unsigned CW    = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          gie,
    input  logic          store_stb,
    input  logic          load_stb,
    input  logic          z0,
    input  logic [DW-1:0] r0_data,
    input  logic [DW-1:0] fuse_bits,
    input  logic          fc_done,
    output logic          fc_erase_go,
    output logic          fc_write_go,
    output logic          pgload_go,
    output logic          pbuf_clr,
    output logic          rww_busy,
    output logic          pbuf_loading,
    output logic [DW-1:0] lock_bits,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    sp_state_e     st_q, st_d;
    sp_cmd_e       cmd_q, dec_cmd;
    logic          dec_arm;
    logic          ie_q;
    logic [CW-1:0] cnt;
    logic          expire, rd_open;
    logic          arm_go, exec;
    logic          prog_go, load_go, reen_go;
    logic          en;

    sp_cmd_decode u_dec (
        .wdata (reg_wdata),
        .arm   (dec_arm),
        .cmd   (dec_cmd)
    );

    sp_window #(.WIN(WIN), .RD_WIN(RD_WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_ARMED),
        .cnt     (cnt),
        .expire  (expire),
        .rd_open (rd_open)
    );

    always_comb begin
        arm_go  = (st_q == ST_IDLE) && reg_wr && dec_arm;
        exec    = (st_q == ST_ARMED) && store_stb;
        prog_go = exec && (cmd_q == CMD_ERASE || cmd_q == CMD_WRITE);
        load_go = exec && (cmd_q == CMD_LOAD);
        reen_go = exec && (cmd_q == CMD_REEN);
    end

    sp_region u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .load_go  (load_go),
        .reen_go  (reen_go),
        .reen_arm (arm_go && dec_cmd == CMD_REEN),
        .busy     (rww_busy),
        .loading  (pbuf_loading)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (arm_go) st_d = ST_ARMED;
            ST_ARMED: begin
                if (prog_go)        st_d = ST_PROG;   // launch
                else if (exec)      st_d = ST_IDLE;   // fire
                else if (expire)    st_d = ST_IDLE;   // lapse
            end
            ST_PROG:  if (fc_done) st_d = ST_IDLE;    // finish
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register and the command latched with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cmd_q <= CMD_LOAD;
        end else begin
            st_q <= st_d;
            if (arm_go)              cmd_q <= dec_cmd;
            else if (st_d == ST_IDLE) cmd_q <= CMD_LOAD;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q        <= 1'b0;
            fc_erase_go <= 1'b0;
            fc_write_go <= 1'b0;
            pgload_go   <= 1'b0;
            pbuf_clr    <= 1'b0;
            lock_bits   <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            if (reg_wr) ie_q <= reg_wdata[B_IE];
            fc_erase_go <= exec && cmd_q == CMD_ERASE;
            fc_write_go <= exec && cmd_q == CMD_WRITE;
            pgload_go   <= load_go;
            pbuf_clr    <= reen_go;
            if (exec && cmd_q == CMD_LOCK) lock_bits <= r0_data;
            rd_valid <= load_stb && rd_open && cmd_q == CMD_LOCK;
            if (load_stb && rd_open && cmd_q == CMD_LOCK)
                rd_data <= z0 ? fuse_bits : lock_bits;
        end
    end

    // readback and interrupt
    always_comb begin
        en                 = (st_q != ST_IDLE);
        reg_rdata          = '0;
        reg_rdata[B_IE]    = ie_q;
        reg_rdata[B_BUSY]  = rww_busy;
        reg_rdata[B_RSVD]  = 1'b0;
        reg_rdata[B_REEN]  = en && cmd_q == CMD_REEN;
        reg_rdata[B_LOCK]  = en && cmd_q == CMD_LOCK;
        reg_rdata[B_WRITE] = en && cmd_q == CMD_WRITE;
        reg_rdata[B_ERASE] = en && cmd_q == CMD_ERASE;
        reg_rdata[B_EN]    = en;
        irq                = ie_q && gie && !en;
    end
endmodule

// File: rtl/selfprog_ctl_chk.sv
`timescale 1ns/1ps
module selfprog_ctl_chk
    import selfprog_pkg::*;
#(
    parameter int unsigned WIN = 4,
    localparam int unsigned CW = $clog2(WIN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input sp_state_e     st,
    input logic [CW-1:0] cnt,
    input logic [7:0]    reg_rdata,
    input logic          irq,
    input logic          fc_erase_go,
    input logic          fc_write_go,
    input logic          pgload_go,
    input logic          pbuf_clr,
    input logic          fc_done,
    input logic          rd_valid,
    input logic          load_stb
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_RSVD] == 1'b0);

    // R3
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !reg_rdata[B_EN]);

    // R4
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_erase_go || fc_write_go) |-> reg_rdata[B_BUSY]);

    // R4
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !fc_done) |=> st == ST_PROG);

    // R4
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fc_erase_go, fc_write_go, pgload_go, pbuf_clr}));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ARMED |-> cnt < CW'(WIN));

    // R6
    clr_unbusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pbuf_clr |-> !reg_rdata[B_BUSY]);

    // R11
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(load_stb));
endmodule

bind selfprog_ctl selfprog_ctl_chk #(.WIN(WIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st_q),
    .cnt         (cnt),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .fc_erase_go (fc_erase_go),
    .fc_write_go (fc_write_go),
    .pgload_go   (pgload_go),
    .pbuf_clr    (pbuf_clr),
    .fc_done     (fc_done),
    .rd_valid    (rd_valid),
    .load_stb    (load_stb)
);

// File: tb/selfprog_ctl_bench.sv
`timescale 1ns/1ps
module selfprog_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       store_stb = 1'b0;
    logic       load_stb = 1'b0;
    logic       z0 = 1'b0;
    logic [7:0] r0_data = '0;
    logic [7:0] fuse_bits = 8'h3C;
    logic       fc_done = 1'b0;
    logic       fc_erase_go, fc_write_go, pgload_go, pbuf_clr;
    logic       rww_busy, pbuf_loading, rd_valid, irq;
    logic [7:0] lock_bits, rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    selfprog_ctl u_selfprog_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gie(gie), .store_stb(store_stb),
        .load_stb(load_stb), .z0(z0), .r0_data(r0_data),
        .fuse_bits(fuse_bits), .fc_done(fc_done), .fc_erase_go(fc_erase_go),
        .fc_write_go(fc_write_go), .pgload_go(pgload_go), .pbuf_clr(pbuf_clr),
        .rww_busy(rww_busy), .pbuf_loading(pbuf_loading),
        .lock_bits(lock_bits), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq(irq)
    );

    // wdata, gie, expected rdata, expected irq (writes with enable clear)
    localparam logic [17:0] VEC [0:6] = '{
        {8'h80, 1'b1, 8'h80, 1'b1},
        {8'h80, 1'b0, 8'h80, 1'b0},
        {8'hFE, 1'b1, 8'h80, 1'b1},
        {8'h00, 1'b1, 8'h00, 1'b0},
        {8'h20, 1'b1, 8'h00, 1'b0},
        {8'h40, 1'b1, 8'h00, 1'b0},
        {8'h9E, 1'b0, 8'h80, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic strobe();
        store_stb = 1'b1;
        step();
        store_stb = 1'b0;
    endtask

    task automatic done_pulse();
        fc_done = 1'b1;
        step();
        fc_done = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq/busy/loading", {5'd0, irq, rww_busy, pbuf_loading}, 8'h00);
        chk("R1 lock", lock_bits, 8'h00);

        // R2 R3 R13 register table
        for (int i = 0; i < 7; i++) begin
            gie = VEC[i][9];
            wr(VEC[i][17:10]);
            chk("R2/R13 rdata", reg_rdata, VEC[i][8:1]);
            chk("R3 irq", {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        gie = 1'b1;
        // R9 page load
        wr(8'h01);
        chk("R9 armed", reg_rdata, 8'h01);
        strobe();
        chk("R9 load pulse", {5'd0, pgload_go, pbuf_loading, rww_busy}, 8'h06);
        chk("R9 rdata idle", reg_rdata, 8'h00);

        // R8 abort load by arming re-enable
        wr(8'h11);
        chk("R8 loading aborted", {7'd0, pbuf_loading}, 8'h00);
        strobe();
        chk("R6 clr pulse", {7'd0, pbuf_clr}, 8'h01);

        // R4 erase with strobe on first edge
        wr(8'h03);
        strobe();
        chk("R4 erase pulse", {6'd0, fc_erase_go, fc_write_go}, 8'h02);
        chk("R4 busy+held", reg_rdata, 8'h43);
        step(2);
        chk("R4 hold", reg_rdata, 8'h43);
        // R7 writes during PROG only touch IE; re-enable dropped
        wr(8'h91);
        chk("R7 ie only", reg_rdata, 8'hC3);
        chk("R4 irq low while prog", {7'd0, irq}, 8'h00);
        strobe();
        chk("R7 busy kept", {6'd0, rww_busy, pbuf_clr}, 8'h02);
        done_pulse();
        chk("R4 done", reg_rdata, 8'hC0);
        chk("R4 irq after done", {7'd0, irq}, 8'h01);

        // R6 re-enable after programming
        wr(8'h91);
        strobe();
        chk("R6 unbusy", {6'd0, rww_busy, pbuf_clr}, 8'h01);
        chk("R6 rdata", reg_rdata, 8'h80);

        // R5 strobe on the 4th edge accepted
        wr(8'h05);
        step(3);
        chk("R5 still armed", reg_rdata, 8'h05);
        strobe();
        chk("R5 write pulse", {6'd0, fc_erase_go, fc_write_go}, 8'h01);
        done_pulse();
        // R5 no strobe: lapse
        wr(8'h03);
        step(3);
        chk("R5 armed at edge 3", reg_rdata, 8'h43);
        step();
        chk("R5 lapsed", reg_rdata, 8'h40);
        strobe();
        chk("R5 late strobe", {6'd0, fc_erase_go, fc_write_go}, 8'h00);

        // R10 lock write
        r0_data = 8'hA5;
        wr(8'h09);
        chk("R10 armed", reg_rdata, 8'h49);
        strobe();
        chk("R10 lock", lock_bits, 8'hA5);
        chk("R10 idle", reg_rdata, 8'h40);

        // R11 readback on 3rd edge, lock then fuse
        wr(8'h09);
        step(2);
        z0 = 1'b0; load_stb = 1'b1; step(); load_stb = 1'b0;
        chk("R11 lock rd", {7'd0, rd_valid}, 8'h01);
        chk("R11 lock data", rd_data, 8'hA5);
        step(2);
        wr(8'h09);
        z0 = 1'b1; load_stb = 1'b1; step(); load_stb = 1'b0;
        chk("R11 fuse data", rd_data, 8'h3C);
        step(4);
        wr(8'h09);
        step(3);
        load_stb = 1'b1; step(); load_stb = 1'b0;
        chk("R11 late rd", {7'd0, rd_valid}, 8'h00);

        // R12 multiple commands ignored
        wr(8'h07);
        chk("R12 not armed", reg_rdata, 8'h40);
        strobe();
        chk("R12 no op", {6'd0, fc_erase_go, fc_write_go}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule